// File: doc/BRIEF.md
# Shared DRAM Controller with Refresh and Byte Parity

This block runs a dynamic RAM array that several bus masters share, typically a local processor and a DMA or backplane bridge. Each master presents a request on a simple level-held synchronous interface and keeps it raised until the controller answers. The controller picks one request, walks a fixed clock-counted row/column strobe sequence and returns an acknowledge after four clocks. A refresh timer with a programmable divisor forces a CAS-before-RAS refresh at a fixed interval. The refresh takes precedence over any waiting access.

On writes the controller adds an even parity bit to every byte lane. On reads it checks every lane. How a parity error is reported depends on where the access came from. A local access still ends with a normal acknowledge and raises an interrupt at a programmed level. An access flagged as coming from the backplane ends with a bus error instead. In both cases the address of the first failing access is held for software until it is cleared, and any further errors only set an overflow flag.

Top module: `dram_share_ctrl`

## Requirements
- R1: After reset all three strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`) are high. No `m_ack` or `m_berr` bit is set, `err_valid` and `err_ovf` are 0 and `irq_level` is 0.
- R2: A request that meets an idle controller with no refresh pending is accepted on the next rising edge. Its `m_ack` (or `m_berr`) bit is high in the cycle that follows the fourth rising edge, including the accepting edge, and it is high for exactly one cycle. On a read, `m_rdata` holds the word read in that cycle.
- R3: During a write, `dram_wpar[k]` is the XOR of the bits of byte k of the write data, so each byte plus its parity bit holds an even number of ones. Reading the same address back returns the written word.
- R4: A refresh starts every `refresh_div` clocks while the controller is idle. A refresh is a CAS-before-RAS cycle: `dram_cas_n` falls while `dram_ras_n` is high, and `dram_ras_n` falls on the next clock. The whole refresh lasts four clocks.
- R5: If a refresh becomes due in the same cycle that an access request arrives, the refresh goes first. The access then acknowledges exactly four clocks later than in R2, which is eight clocks after the request.
- R6: Waiting requests are served in arrival order, using an age count per master. When requests arrive in the same cycle, the lowest master index is served first.
- R7: A read lane fails when its byte XOR its parity bit is 1. On a failing read from a master whose `m_remote` bit is 0, the access still gets a normal `m_ack` with the data. `irq_level` then shows `irq_cfg_lvl` (1 to 7) until it is cleared. Writes never flag an error.
- R8: On a failing read from a master whose `m_remote` bit is 1, `m_berr` is returned instead of `m_ack`, and `irq_level` is not raised. A clean remote read gets `m_ack`.
- R9: The first parity error sets `err_valid` and latches the access address into `err_addr`. Any later error leaves `err_addr` unchanged and sets `err_ovf`.
- R10: A one-cycle pulse on `err_clr` clears `err_valid`, `err_ovf` and `irq_level` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Per-master request, held until answered |
| m_we | input | NM | Per-master write select |
| m_remote | input | NM | Per-master flag: access originates on the backplane |
| m_addr | input | NM*AW | Per-master address, master i in slice i |
| m_wdata | input | NM*DW | Per-master write data, master i in slice i |
| m_ack | output | NM | Per-master normal completion pulse |
| m_berr | output | NM | Per-master bus error pulse |
| m_rdata | output | DW | Read data, valid with the completion pulse |
| refresh_div | input | REF_W | Refresh interval in clocks |
| irq_cfg_lvl | input | LVL_W | Interrupt level for local parity errors |
| err_clr | input | 1 | Clears the error record and the interrupt |
| err_valid | output | 1 | An error address is held |
| err_ovf | output | 1 | More errors arrived after the first one |
| err_addr | output | AW | Address of the first failing access |
| irq_level | output | LVL_W | Active interrupt level, 0 when none is pending |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_col_sel | output | 1 | Address multiplexer selects the column half |
| dram_addr | output | AW | Address of the current access |
| dram_wdata | output | DW | Write data to the array |
| dram_wpar | output | DW/8 | Write parity per byte lane |
| dram_rdata | input | DW | Read data from the array |
| dram_rpar | input | DW/8 | Read parity per byte lane |

## Verification
The bench times a request so that it arrives in the same cycle the refresh becomes due. A controller that let the access win, or that lost a cycle after the refresh, would show a latency other than eight. A second case has one master re-request behind a master that has already been waiting. A fixed-priority arbiter would serve the lower index first, which the bench sees from the order of the completion pulses. The parity cases corrupt one stored bit and then read it from a local master and then a remote master. A design that mixed up the two kinds of signalling would send a bus error to the processor or raise the interrupt for the backplane. A design that overwrote the held address on the second error would report the wrong `err_addr`. Randomly mixed traffic, with and without a short refresh period, checks read data against a shadow copy kept by the bench.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAS,
    ST_CAS,
    ST_CAS2,
    ST_DONE,
    ST_RF1,
    ST_RF2,
    ST_RF3,
    ST_RF4
  } seq_st_t;

  // Even parity bit for one byte lane
  function automatic logic byte_par(input logic [7:0] b);
    return ^b;
  endfunction

  // One when a lane and its stored parity disagree
  function automatic logic lane_bad(input logic [7:0] b, input logic p);
    return (^b) ^ p;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] div,
  input  logic             start,
  output logic             pend
);

  logic [REF_W-1:0] cnt_q;
  logic             interval_hit;

  assign interval_hit = ({1'b0, cnt_q} + (REF_W+1)'(1)) >= {1'b0, div};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      cnt_q <= interval_hit ? '0 : cnt_q + 1'b1;
      pend  <= (pend && !start) || interval_hit;
    end
  end

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !start) |=> pend);

endmodule

// File: rtl/dram_age_arb.sv
module dram_age_arb #(
  parameter int NM    = 2,
  parameter int AGE_W = 4,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req,
  input  logic [NM-1:0]    svc,
  output logic             any,
  output logic [IDX_W-1:0] pick
);

  logic [AGE_W-1:0] age_q [NM];
  logic [AGE_W-1:0] best;
  logic             found;

  for (genvar i = 0; i < NM; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                     age_q[i] <= '0;
      else if (!req[i] || svc[i])     age_q[i] <= '0;
      else if (age_q[i] != '1)        age_q[i] <= age_q[i] + 1'b1;
    end
  end

  assign any = |req;

  // Oldest waiting request wins; strict compare keeps the lowest index on ties
  always_comb begin
    pick  = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (req[i] && (!found || age_q[i] > best)) begin
        pick  = IDX_W'(i);
        best  = age_q[i];
        found = 1'b1;
      end
    end
  end

  // R6
  pick_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[pick]);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctl_pkg::*;
#(
  parameter int NM    = 2,
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int IDX_W = 1,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pend,
  input  logic             arb_any,
  input  logic [IDX_W-1:0] arb_pick,
  input  logic [NM-1:0]    req_we,
  input  logic [NM-1:0]    req_rem,
  input  logic [NM*AW-1:0] req_addr,
  input  logic [NM*DW-1:0] req_wdata,
  output logic             ref_start,
  output logic [NM-1:0]    svc,
  output logic [NM-1:0]    ack,
  output logic [NM-1:0]    berr,
  output logic [DW-1:0]    rdata,
  output logic             rd_done,
  output logic             par_bad,
  output logic [AW-1:0]    cur_addr,
  output logic             cur_rem,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             col_sel,
  output logic [LANES-1:0] wpar,
  output logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    dram_rdata,
  input  logic [LANES-1:0] dram_rpar
);

  seq_st_t          state_q, state_d;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_we;
  logic [DW-1:0]    cur_wd;
  logic [DW-1:0]    rd_q;
  logic [LANES-1:0] rp_q;
  logic             decide, accept, in_acc, done;

  function automatic logic word_bad(input logic [DW-1:0] d, input logic [LANES-1:0] p);
    logic r;
    r = 1'b0;
    for (int k = 0; k < LANES; k++) r = r | lane_bad(d[8*k +: 8], p[k]);
    return r;
  endfunction

  assign decide    = (state_q == ST_IDLE) || (state_q == ST_RF4);
  assign ref_start = decide && ref_pend;
  assign accept    = decide && !ref_pend && arb_any;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RF4: state_d = ref_pend ? ST_RF1 : (arb_any ? ST_RAS : ST_IDLE);
      ST_RAS:  state_d = ST_CAS;
      ST_CAS:  state_d = ST_CAS2;
      ST_CAS2: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_RF1:  state_d = ST_RF2;
      ST_RF2:  state_d = ST_RF3;
      ST_RF3:  state_d = ST_RF4;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_idx  <= '0;
      cur_we   <= 1'b0;
      cur_rem  <= 1'b0;
      cur_addr <= '0;
      cur_wd   <= '0;
      rd_q     <= '0;
      rp_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_idx  <= arb_pick;
        cur_we   <= req_we[arb_pick];
        cur_rem  <= req_rem[arb_pick];
        cur_addr <= req_addr[arb_pick*AW +: AW];
        cur_wd   <= req_wdata[arb_pick*DW +: DW];
      end
      if (state_q == ST_CAS2) begin
        rd_q <= dram_rdata;
        rp_q <= dram_rpar;
      end
    end
  end

  assign in_acc  = (state_q == ST_RAS) || (state_q == ST_CAS) ||
                   (state_q == ST_CAS2) || (state_q == ST_DONE);
  assign done    = state_q == ST_DONE;
  assign rd_done = done && !cur_we;
  assign par_bad = word_bad(rd_q, rp_q);
  assign rdata   = rd_q;

  for (genvar i = 0; i < NM; i++) begin : g_port
    assign svc[i]  = in_acc && (cur_idx == IDX_W'(i));
    assign ack[i]  = done && (cur_idx == IDX_W'(i)) && !(rd_done && par_bad && cur_rem);
    assign berr[i] = done && (cur_idx == IDX_W'(i)) && rd_done && par_bad && cur_rem;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_wpar
    assign wpar[k] = byte_par(cur_wd[8*k +: 8]);
  end
  assign wdata = cur_wd;

  always_comb begin
    ras_n   = 1'b1;
    cas_n   = 1'b1;
    col_sel = 1'b0;
    unique case (state_q)
      ST_RAS:          ras_n = 1'b0;
      ST_CAS, ST_CAS2: begin ras_n = 1'b0; cas_n = 1'b0; col_sel = 1'b1; end
      ST_RF1:          cas_n = 1'b0;
      ST_RF2, ST_RF3:  begin ras_n = 1'b0; cas_n = 1'b0; end
      default: ;
    endcase
  end
  assign we_n = !(cur_we && col_sel);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack || |berr) |=> !(|ack || |berr));

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> !ras_n);

  // R2
  ras_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |=> !cas_n);

endmodule

// File: rtl/dram_par_log.sv
module dram_par_log #(
  parameter int AW    = 24,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_done,
  input  logic             bad,
  input  logic [AW-1:0]    addr_in,
  input  logic             remote,
  input  logic             clr,
  input  logic [LVL_W-1:0] cfg_lvl,
  output logic             err_valid,
  output logic             err_ovf,
  output logic [AW-1:0]    err_addr,
  output logic [LVL_W-1:0] irq_level
);

  logic err_hit, irq_pend;

  assign err_hit = rd_done && bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_ovf   <= 1'b0;
      err_addr  <= '0;
      irq_pend  <= 1'b0;
    end else if (clr) begin
      err_valid <= err_hit;
      err_ovf   <= 1'b0;
      irq_pend  <= err_hit && !remote;
      if (err_hit) err_addr <= addr_in;
    end else if (err_hit) begin
      if (!err_valid) begin
        err_valid <= 1'b1;
        err_addr  <= addr_in;
      end else begin
        err_ovf <= 1'b1;
      end
      if (!remote) irq_pend <= 1'b1;
    end
  end

  assign irq_level = irq_pend ? cfg_lvl : '0;

  // R9
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !clr) |=> (err_valid && $stable(err_addr)));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_hit) |=> (!err_valid && !err_ovf && irq_level == '0));

endmodule

// File: rtl/dram_share_ctrl.sv
module dram_share_ctrl #(
  parameter int NM    = 2,
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int REF_W = 16,
  parameter int AGE_W = 4,
  parameter int LVL_W = 3,
  localparam int LANES = DW / 8,
  localparam int IDX_W = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [NM-1:0]    m_we,
  input  logic [NM-1:0]    m_remote,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*DW-1:0] m_wdata,
  output logic [NM-1:0]    m_ack,
  output logic [NM-1:0]    m_berr,
  output logic [DW-1:0]    m_rdata,
  input  logic [REF_W-1:0] refresh_div,
  input  logic [LVL_W-1:0] irq_cfg_lvl,
  input  logic             err_clr,
  output logic             err_valid,
  output logic             err_ovf,
  output logic [AW-1:0]    err_addr,
  output logic [LVL_W-1:0] irq_level,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_col_sel,
  output logic [AW-1:0]    dram_addr,
  output logic [DW-1:0]    dram_wdata,
  output logic [LANES-1:0] dram_wpar,
  input  logic [DW-1:0]    dram_rdata,
  input  logic [LANES-1:0] dram_rpar
);

  logic             ref_pend, ref_start, arb_any;
  logic [IDX_W-1:0] arb_pick;
  logic [NM-1:0]    svc;
  logic             rd_done, par_bad, cur_rem;
  logic [AW-1:0]    cur_addr;

  dram_ref_timer #(.REF_W(REF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .div(refresh_div), .start(ref_start), .pend(ref_pend)
  );

  dram_age_arb #(.NM(NM), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(m_req), .svc(svc), .any(arb_any), .pick(arb_pick)
  );

  dram_seq #(.NM(NM), .AW(AW), .DW(DW), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_pend(ref_pend), .arb_any(arb_any), .arb_pick(arb_pick),
    .req_we(m_we), .req_rem(m_remote), .req_addr(m_addr), .req_wdata(m_wdata),
    .ref_start(ref_start), .svc(svc), .ack(m_ack), .berr(m_berr), .rdata(m_rdata),
    .rd_done(rd_done), .par_bad(par_bad), .cur_addr(cur_addr), .cur_rem(cur_rem),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .col_sel(dram_col_sel),
    .wpar(dram_wpar), .wdata(dram_wdata), .dram_rdata(dram_rdata), .dram_rpar(dram_rpar)
  );

  assign dram_addr = cur_addr;

  dram_par_log #(.AW(AW), .LVL_W(LVL_W)) u_log (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .bad(par_bad), .addr_in(cur_addr),
    .remote(cur_rem), .clr(err_clr), .cfg_lvl(irq_cfg_lvl), .err_valid(err_valid),
    .err_ovf(err_ovf), .err_addr(err_addr), .irq_level(irq_level)
  );

endmodule

// File: tb/dram_share_ctrl_tb_top.sv
module dram_share_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  m_req, m_we, m_remote, m_ack, m_berr;
  logic [47:0] m_addr;
  logic [63:0] m_wdata;
  logic [31:0] m_rdata;
  logic [15:0] refresh_div;
  logic [2:0]  irq_cfg_lvl, irq_level;
  logic        err_clr, err_valid, err_ovf;
  logic [23:0] err_addr, dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_col_sel;
  logic [31:0] dram_wdata, dram_rdata;
  logic [3:0]  dram_wpar, dram_rpar;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_share_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_remote(m_remote),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_berr(m_berr), .m_rdata(m_rdata),
    .refresh_div(refresh_div), .irq_cfg_lvl(irq_cfg_lvl), .err_clr(err_clr),
    .err_valid(err_valid), .err_ovf(err_ovf), .err_addr(err_addr), .irq_level(irq_level),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_col_sel(dram_col_sel), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
    .dram_wpar(dram_wpar), .dram_rdata(dram_rdata), .dram_rpar(dram_rpar)
  );

  // Array model: 64 words of {parity, data}, with a fault injection port
  logic [35:0] mem [64];
  logic        corr_en;
  logic [5:0]  corr_idx;
  logic [35:0] corr_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else if (corr_en) begin
      mem[corr_idx] <= mem[corr_idx] ^ corr_mask;
    end else if (!dram_ras_n && !dram_cas_n && !dram_we_n) begin
      mem[dram_addr[5:0]] <= {dram_wpar, dram_wdata};
    end
  end
  assign {dram_rpar, dram_rdata} = mem[dram_addr[5:0]];

  logic [31:0] shadow [64];

  function automatic logic [3:0] exp_par(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += d[8*k + b];
      p[k] = (ones % 2) == 1;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Raise a request at a falling edge, wait for the answer, drop it, idle one cycle
  task automatic do_acc(input int m, input logic wr, input logic [23:0] a,
                        input logic [31:0] d, input logic rem,
                        output int lat, output logic [31:0] rd, output logic gack,
                        output logic gberr, output logic [3:0] wp, output logic pulse_ok);
    m_we[m] = wr;
    m_remote[m] = rem;
    m_addr[m*24 +: 24] = a;
    m_wdata[m*32 +: 32] = d;
    m_req[m] = 1'b1;
    lat = 0; gack = 1'b0; gberr = 1'b0; wp = '0; rd = '0;
    while (!gack && !gberr && lat < 60) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (!dram_cas_n && !dram_we_n) wp = dram_wpar;
      gack = m_ack[m];
      gberr = m_berr[m];
      rd = m_rdata;
    end
    m_req[m] = 1'b0;
    @(negedge clk);
    pulse_ok = !m_ack[m] && !m_berr[m];
  endtask

  task automatic wait_rf1(output int c);
    do @(negedge clk); while (!(!dram_cas_n && dram_ras_n));
    c = cyc;
  endtask

  task automatic corrupt(input int idx, input logic [35:0] mask);
    corr_idx = idx[5:0];
    corr_mask = mask;
    corr_en = 1'b1;
    @(negedge clk);
    corr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat, lat0, lat1, c1, c2;
    logic [31:0] rd, rd0, rd1, d;
    logic ga, gb, ga0, gb0, ga1, gb1, pk, pk0, pk1;
    logic [3:0] wp, wp0, wp1;

    rst_n = 1'b0; m_req = '0; m_we = '0; m_remote = '0; m_addr = '0; m_wdata = '0;
    refresh_div = 16'hFFFF; irq_cfg_lvl = 3'd5; err_clr = 1'b0;
    corr_en = 1'b0; corr_idx = '0; corr_mask = '0;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    void'($urandom(32'd7391));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle",
          {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    check(m_ack == 0 && m_berr == 0, "R1", "no completion", {m_ack, m_berr}, 0);
    check(!err_valid && !err_ovf, "R1", "error record empty", {err_valid, err_ovf}, 0);
    check(irq_level == 0, "R1", "no interrupt", irq_level, 0);

    // R2 / R3 directed write and read
    d = 32'hA5C3_0F81;
    do_acc(0, 1'b1, 24'd3, d, 1'b0, lat, rd, ga, gb, wp, pk);
    shadow[3] = d;
    check(lat == 4 && ga, "R2", "write latency", lat, 4);
    check(pk, "R2", "ack one cycle", pk, 1);
    check(wp == exp_par(d), "R3", "write parity", wp, exp_par(d));
    do_acc(0, 1'b0, 24'd3, 32'h0, 1'b0, lat, rd, ga, gb, wp, pk);
    check(lat == 4 && ga && !gb, "R2", "read latency", lat, 4);
    check(rd == d, "R3", "read back", rd, d);
    check(err_valid == 0, "R7", "clean read no error", err_valid, 0);

    // R8 clean remote read is acknowledged normally
    do_acc(1, 1'b0, 24'd3, 32'h0, 1'b1, lat, rd, ga, gb, wp, pk);
    check(ga && !gb && rd == d, "R8", "clean remote read ack", {ga, gb}, 2'b10);

    // R6 same-cycle tie: lower index first
    fork
      do_acc(0, 1'b0, 24'd3, 32'h0, 1'b0, lat0, rd0, ga0, gb0, wp0, pk0);
      do_acc(1, 1'b0, 24'd3, 32'h0, 1'b0, lat1, rd1, ga1, gb1, wp1, pk1);
    join
    check(lat0 == 4, "R6", "tie master0 latency", lat0, 4);
    check(lat1 == 9, "R6", "tie master1 latency", lat1, 9);

    // R6 arrival order: master1 waits, master0 re-requests later and must queue behind it
    fork
      begin
        do_acc(0, 1'b0, 24'd3, 32'h0, 1'b0, lat0, rd0, ga0, gb0, wp0, pk0);
        do_acc(0, 1'b0, 24'd3, 32'h0, 1'b0, lat0, rd0, ga0, gb0, wp0, pk0);
      end
      begin
        repeat (2) @(negedge clk);
        do_acc(1, 1'b0, 24'd3, 32'h0, 1'b0, lat1, rd1, ga1, gb1, wp1, pk1);
      end
    join
    check(lat1 == 7, "R6", "older master1 served first", lat1, 7);
    check(lat0 == 9, "R6", "later master0 served second", lat0, 9);

    // R7 / R9 local parity error
    d = 32'h1234_5678;
    do_acc(0, 1'b1, 24'd40, d, 1'b0, lat, rd, ga, gb, wp, pk);
    check(err_valid == 0, "R7", "write flags no error", err_valid, 0);
    corrupt(40, 36'h2_0000_0000);
    do_acc(0, 1'b0, 24'd40, 32'h0, 1'b0, lat, rd, ga, gb, wp, pk);
    check(ga && !gb && lat == 4, "R7", "local error still acks", {ga, gb}, 2'b10);
    check(rd == d, "R7", "local error data", rd, d);
    check(irq_level == 3'd5, "R7", "irq level", irq_level, 5);
    check(err_valid && err_addr == 24'd40, "R9", "first address", err_addr, 40);
    check(!err_ovf, "R9", "no overflow yet", err_ovf, 0);

    // R8 / R9 remote error on same word: bus error, overflow, address kept
    do_acc(1, 1'b0, 24'd40, 32'h0, 1'b1, lat, rd, ga, gb, wp, pk);
    check(gb && !ga, "R8", "remote error berr", {ga, gb}, 2'b01);
    check(err_ovf && err_addr == 24'd40, "R9", "overflow keeps address", err_addr, 40);

    // R10 clear
    pulse_clr();
    check(!err_valid && !err_ovf && irq_level == 0, "R10", "cleared",
          {err_valid, err_ovf, irq_level}, 0);

    // R8 remote-only error: captured, no interrupt
    d = 32'hDEAD_BEEF;
    do_acc(1, 1'b1, 24'd41, d, 1'b1, lat, rd, ga, gb, wp, pk);
    corrupt(41, 36'h0_0000_0020);
    do_acc(1, 1'b0, 24'd41, 32'h0, 1'b1, lat, rd, ga, gb, wp, pk);
    check(gb && !ga, "R8", "remote data-bit error berr", {ga, gb}, 2'b01);
    check(irq_level == 0, "R8", "no irq on remote error", irq_level, 0);
    check(err_valid && err_addr == 24'd41, "R9", "remote address captured", err_addr, 41);
    pulse_clr();
    check(!err_valid && irq_level == 0, "R10", "cleared again", {err_valid, irq_level}, 0);

    // Random traffic without refresh: fixed latency, data and parity
    for (int n = 0; n < 30; n++) begin
      int m = $urandom_range(0, 1);
      logic wr = $urandom_range(0, 1);
      int a = $urandom_range(0, 31);
      logic [31:0] wd = $urandom;
      do_acc(m, wr, 24'(a), wd, 1'b0, lat, rd, ga, gb, wp, pk);
      check(ga && lat == 4, "R2", "random latency", lat, 4);
      if (wr) begin
        shadow[a] = wd;
        check(wp == exp_par(wd), "R3", "random write parity", wp, exp_par(wd));
      end else begin
        check(rd == shadow[a], "R3", "random read data", rd, shadow[a]);
      end
    end

    // R4 refresh interval and shape
    refresh_div = 16'd40;
    wait_rf1(c1);
    @(negedge clk);
    check(!dram_ras_n && !dram_cas_n, "R4", "RAS follows CAS", {dram_ras_n, dram_cas_n}, 0);
    wait_rf1(c2);
    check(c2 - c1 == 40, "R4", "refresh interval", c2 - c1, 40);

    // R5 request arriving as the refresh becomes due
    repeat (39) @(negedge clk);
    do_acc(0, 1'b0, 24'd3, 32'h0, 1'b0, lat, rd, ga, gb, wp, pk);
    check(ga && lat == 8, "R5", "refresh delays access by four", lat, 8);
    check(rd == shadow[3], "R5", "data after refresh", rd, shadow[3]);

    // Random traffic with a short refresh period
    refresh_div = 16'd23;
    for (int n = 0; n < 30; n++) begin
      int m = $urandom_range(0, 1);
      logic wr = $urandom_range(0, 1);
      logic rem = $urandom_range(0, 1);
      int a = $urandom_range(0, 31);
      logic [31:0] wd = $urandom;
      do_acc(m, wr, 24'(a), wd, rem, lat, rd, ga, gb, wp, pk);
      check(ga && lat >= 4 && lat <= 8, "R5", "latency with refresh", lat, 4);
      if (wr) shadow[a] = wd;
      else check(rd == shadow[a], "R3", "read data with refresh", rd, shadow[a]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule